// File: doc/BRIEF.md
# PCM Audio Serializer

This block turns parallel stereo audio samples into the three-wire serial stream an external DAC expects: a bit clock, a word clock that marks left and right channels, and a serial data line. All three are produced from a single fast master clock. A programmable divider sets the bit-clock rate, and a small set of format controls picks the slot width, sample precision, bit order, placement of the sample inside its slot, framing style and the polarity of both clocks.

Samples arrive as a left/right pair with a valid/ready handshake. The serializer asks for one pair per word-clock period, at the boundary between frames. If no pair is offered, it sends a silent frame. The format controls are plain input ports. They are sampled only at a frame boundary, so changing them mid-frame never corrupts the frame in flight.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held, and until the first frame starts, `bclk` is high, `lrck` is low, `sdata` is low and `in_ready` is low.
- R2: Each bit-clock level lasts `cfg_div`+1 master cycles, so one bit period is 2×(`cfg_div`+1) master cycles. A value of 0 gives half the master rate.
- R3: `cfg_prec` = 0 sends 16-bit samples in 16-bit slots (32-bit frame). Codes 1, 2 and 3 send 18-, 20- and 24-bit samples in 32-bit slots (64-bit frame). An n-bit sample is taken from bits n-1:0 of its input word, and the higher input bits are ignored.
- R4: In 16-bit mode, `cfg_lsb_first` = 1 sends bit 0 first and 0 sends bit 15 first. In 32-bit slot modes this control has no effect, and the MSB always goes first.
- R5: In 32-bit slot modes, `cfg_right_align` = 0 puts the sample MSB in the first slot bit and fills the rest of the slot with zeros. `cfg_right_align` = 1 leads with zeros so that the sample LSB is the last slot bit. In 16-bit mode this control has no effect.
- R6: With `cfg_lr_invert` = 0 the left slot is sent while `lrck` is low. With `cfg_lr_invert` = 1 it is sent while `lrck` is high.
- R7: With `cfg_alt_frame` = 0 (I2S framing), `lrck` switches one bit period before the first bit of a slot. With `cfg_alt_frame` = 1 it switches together with that first bit.
- R8: With `cfg_bclk_invert` = 0, `sdata` and `lrck` change only on falling `bclk` edges and are stable at rising edges. With `cfg_bclk_invert` = 1 the roles of the two edges swap.
- R9: `in_ready` is high for exactly one master cycle per frame, at the frame boundary. The pair on `left_in`/`right_in` is taken in that cycle when `in_valid` is high, and the first slot bit sent after it is bit 0 of the new frame.
- R10: If `in_valid` is low during the `in_ready` cycle, the whole next frame is sent as zeros on `sdata`.
- R11: All configuration inputs, the divider included, are sampled only in the `in_ready` cycle and hold for the whole frame that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master PCM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Bit-clock divider value |
| cfg_lsb_first | input | 1 | LSB-first order in 16-bit mode |
| cfg_right_align | input | 1 | Right-aligned placement in 32-bit slots |
| cfg_lr_invert | input | 1 | Left channel on high word clock |
| cfg_bclk_invert | input | 1 | Invert bit-clock polarity |
| cfg_alt_frame | input | 1 | Word clock aligned with first data bit |
| cfg_prec | input | 2 | Sample precision code |
| left_in | input | 24 | Left sample, right-justified in the word |
| right_in | input | 24 | Right sample, right-justified in the word |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair taken this cycle (frame boundary) |
| bclk | output | 1 | Bit clock to the DAC |
| lrck | output | 1 | Word (left/right) clock |
| sdata | output | 1 | Serial data |

## Verification
The assertions assume only that reset is held for at least one master cycle. They assume nothing about how the configuration ports move, because the design itself guards frame integrity, and the word-clock alignment property is skipped on the one edge where a new configuration is loaded. The bench depends on one thing that the assertions do not: it keeps the bit-clock inversion fixed within a run, because it reads data on the edge that inversion selects. All other controls, the divider included, change at random in the middle of frames. Sample words carry random upper bits beyond the selected precision, and valid is sometimes withheld to produce silent frames.

// File: rtl/pcm_serial_pkg.sv
// Package for the PCM serializer: format type, precision codes and
// fixed widths of the sample path.
package pcm_serial_pkg;

    localparam int SAMPLE_W = 24;   // widest sample precision
    localparam int POS_W    = 6;    // bit position within a 64-bit frame

    typedef enum logic [1:0] {
        PREC_16 = 2'd0,
        PREC_18 = 2'd1,
        PREC_20 = 2'd2,
        PREC_24 = 2'd3
    } prec_e;

    typedef struct packed {
        logic  lsb_first;
        logic  right_align;
        logic  lr_invert;
        logic  bclk_invert;
        logic  alt_frame;
        prec_e prec;
    } fmt_t;

    // Number of significant sample bits for a precision code.
    function automatic logic [4:0] prec_width(input prec_e p);
        case (p)
            PREC_16: prec_width = 5'd16;
            PREC_18: prec_width = 5'd18;
            PREC_20: prec_width = 5'd20;
            default: prec_width = 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/pcm_bclk_gen.sv
// Bit-clock generator. Divides the master clock by 2*(div+1) and produces
// an internal bit-clock phase together with a one-cycle enable in the
// master cycle just before each falling phase transition.
// Assumes: div is stable within a bit period (the caller updates it only
// together with a falling transition).
module pcm_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             fall_tick,
    output logic             bclk_raw
);

    logic [DIV_W-1:0] cnt_q;
    logic             run_q;

    // Falling transition is due when the phase counter ends a high phase.
    always_comb begin
        fall_tick = run_q && (cnt_q == div) && bclk_raw;
    end

    // Phase counter and bit-clock phase; idle for one cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bclk_raw <= 1'b1;
            run_q    <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                if (cnt_q == div) begin
                    cnt_q    <= '0;
                    bclk_raw <= ~bclk_raw;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_frame_seq.sv
// Frame sequencer. Tracks the bit position within the frame, raises the
// ready strobe at each frame boundary, and latches format, divider and
// the sample pair there. It also presents the "next" view (the values
// that apply to the bit about to be driven) to the bit selector.
// Assumes: fall_tick is a single-cycle enable from the bit-clock generator.
module pcm_frame_seq
    import pcm_serial_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_tick,
    input  logic [DIV_W-1:0]    cfg_div,
    input  fmt_t                cfg_fmt,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                in_valid,
    output logic                in_ready,
    output fmt_t                fmt_q,
    output logic [DIV_W-1:0]    div_q,
    output logic [POS_W-1:0]    pos_q,
    output logic [SAMPLE_W-1:0] left_q,
    output logic [SAMPLE_W-1:0] right_q,
    output fmt_t                nxt_fmt,
    output logic [POS_W-1:0]    nxt_pos,
    output logic [SAMPLE_W-1:0] nxt_left,
    output logic [SAMPLE_W-1:0] nxt_right
);

    logic [POS_W-1:0] last_pos;
    logic             frame_tick;

    // Boundary detection and the values that apply to the next bit.
    always_comb begin
        last_pos   = (fmt_q.prec == PREC_16) ? POS_W'(31) : POS_W'(63);
        frame_tick = fall_tick && (pos_q == last_pos);
        in_ready   = frame_tick;
        nxt_fmt    = frame_tick ? cfg_fmt : fmt_q;
        nxt_pos    = frame_tick ? '0 : POS_W'(pos_q + 1'b1);
        nxt_left   = frame_tick ? (in_valid ? left_in  : '0) : left_q;
        nxt_right  = frame_tick ? (in_valid ? right_in : '0) : right_q;
    end

    // Position, format, divider and sample registers; advance once per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= POS_W'(31);
            fmt_q   <= '0;
            div_q   <= '0;
            left_q  <= '0;
            right_q <= '0;
        end else if (fall_tick) begin
            pos_q   <= nxt_pos;
            fmt_q   <= nxt_fmt;
            left_q  <= nxt_left;
            right_q <= nxt_right;
            if (frame_tick) begin
                div_q <= cfg_div;
            end
        end
    end

endmodule

// File: rtl/pcm_bit_pick.sv
// Bit selector. Purely combinational: for a frame position and format it
// returns the data bit and the word-clock level to drive.
// Assumes: pos lies inside the frame length implied by fmt.prec.
module pcm_bit_pick
    import pcm_serial_pkg::*;
(
    input  fmt_t                fmt,
    input  logic [POS_W-1:0]    pos,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    output logic                bit_o,
    output logic                lr_o
);

    logic                is16;
    logic                right_ch;
    logic [4:0]          slot;
    logic [4:0]          nb;
    logic [5:0]          lead;
    logic [4:0]          idx;
    logic [POS_W-1:0]    look;
    logic [SAMPLE_W-1:0] smp;

    // Slot decode, bit placement and word-clock level.
    always_comb begin
        is16     = (fmt.prec == PREC_16);
        slot     = is16 ? {1'b0, pos[3:0]} : pos[4:0];
        right_ch = is16 ? pos[4] : pos[5];
        smp      = right_ch ? right : left;
        nb       = prec_width(fmt.prec);
        lead     = 6'd32 - {1'b0, nb};
        idx      = '0;
        bit_o    = 1'b0;
        if (is16) begin
            idx   = fmt.lsb_first ? slot : (5'd15 - slot);
            bit_o = smp[idx];
        end else if (fmt.right_align) begin
            if ({1'b0, slot} >= lead) begin
                idx   = 5'd31 - slot;
                bit_o = smp[idx];
            end
        end else if (slot < nb) begin
            idx   = nb - 5'd1 - slot;
            bit_o = smp[idx];
        end
        look = fmt.alt_frame ? pos : POS_W'(pos + 1'b1);
        lr_o = (is16 ? look[4] : look[5]) ^ fmt.lr_invert;
    end

endmodule

// File: rtl/pcm_serial_tx.sv
// PCM serializer top. Joins the bit-clock generator, frame sequencer and
// bit selector, and registers the serial data and word clock so that they
// change only together with the falling internal bit-clock phase.
// Assumes: configuration inputs may change at any time; they are used
// from the next frame boundary onward.
module pcm_serial_tx
    import pcm_serial_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_lsb_first,
    input  logic                cfg_right_align,
    input  logic                cfg_lr_invert,
    input  logic                cfg_bclk_invert,
    input  logic                cfg_alt_frame,
    input  logic [1:0]          cfg_prec,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                bclk,
    output logic                lrck,
    output logic                sdata
);

    fmt_t                cfg_fmt;
    fmt_t                fmt_q;
    fmt_t                nxt_fmt;
    logic [DIV_W-1:0]    div_q;
    logic [POS_W-1:0]    pos_q;
    logic [POS_W-1:0]    nxt_pos;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic [SAMPLE_W-1:0] nxt_left;
    logic [SAMPLE_W-1:0] nxt_right;
    logic                fall_tick;
    logic                bclk_raw;
    logic                pick_bit;
    logic                pick_lr;

    // Gather the configuration ports into one format word.
    always_comb begin
        cfg_fmt.lsb_first   = cfg_lsb_first;
        cfg_fmt.right_align = cfg_right_align;
        cfg_fmt.lr_invert   = cfg_lr_invert;
        cfg_fmt.bclk_invert = cfg_bclk_invert;
        cfg_fmt.alt_frame   = cfg_alt_frame;
        cfg_fmt.prec        = prec_e'(cfg_prec);
    end

    pcm_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_q),
        .fall_tick (fall_tick),
        .bclk_raw  (bclk_raw)
    );

    pcm_frame_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tick (fall_tick),
        .cfg_div   (cfg_div),
        .cfg_fmt   (cfg_fmt),
        .left_in   (left_in),
        .right_in  (right_in),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .fmt_q     (fmt_q),
        .div_q     (div_q),
        .pos_q     (pos_q),
        .left_q    (left_q),
        .right_q   (right_q),
        .nxt_fmt   (nxt_fmt),
        .nxt_pos   (nxt_pos),
        .nxt_left  (nxt_left),
        .nxt_right (nxt_right)
    );

    pcm_bit_pick u_pick (
        .fmt   (nxt_fmt),
        .pos   (nxt_pos),
        .left  (nxt_left),
        .right (nxt_right),
        .bit_o (pick_bit),
        .lr_o  (pick_lr)
    );

    // Output registers for data and word clock, loaded on the falling phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata <= 1'b0;
            lrck  <= 1'b0;
        end else if (fall_tick) begin
            sdata <= pick_bit;
            lrck  <= pick_lr;
        end
    end

    // Bit-clock pin with the frame's polarity applied.
    always_comb begin
        bclk = bclk_raw ^ fmt_q.bclk_invert;
    end

endmodule

// File: rtl/pcm_serial_chk.sv
// Property checker for the PCM serializer, bound to the top module.
// Observes ports and the sequencer/generator state; drives nothing.
module pcm_serial_chk
    import pcm_serial_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                bclk_raw,
    input logic                sdata,
    input logic                lrck,
    input logic [POS_W-1:0]    pos_q,
    input fmt_t                fmt_q,
    input logic [SAMPLE_W-1:0] left_q,
    input logic [SAMPLE_W-1:0] right_q
);

    logic [4:0] nb;
    logic [5:0] lead;
    logic       is16;
    logic [4:0] slot;
    logic [4:0] slot_last;

    // Decode of the latched format for the properties below.
    always_comb begin
        is16      = (fmt_q.prec == PREC_16);
        nb        = prec_width(fmt_q.prec);
        lead      = 6'd32 - {1'b0, nb};
        slot      = is16 ? {1'b0, pos_q[3:0]} : pos_q[4:0];
        slot_last = is16 ? 5'd15 : 5'd31;
    end

    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    p_ready_frame_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (pos_q == '0));

    p_silent_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (left_q == '0 && right_q == '0));

    p_change_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdata) || !$stable(lrck)) |-> $fell(bclk_raw));

    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is16 && !fmt_q.right_align && pos_q[4:0] >= nb) |-> !sdata);

    p_lead_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is16 && fmt_q.right_align && {1'b0, pos_q[4:0]} < lead) |-> !sdata);

    p_lrck_alt_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lrck) && $stable(fmt_q) && fmt_q.alt_frame) |-> (slot == 5'd0));

    p_lrck_i2s_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lrck) && $stable(fmt_q) && !fmt_q.alt_frame) |-> (slot == slot_last));

endmodule

bind pcm_serial_tx pcm_serial_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bclk_raw (bclk_raw),
    .sdata    (sdata),
    .lrck     (lrck),
    .pos_q    (pos_q),
    .fmt_q    (fmt_q),
    .left_q   (left_q),
    .right_q  (right_q)
);

// File: tb/pcm_serial_tx_tb.sv
module pcm_serial_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int MAX_CAP    = 512;
    localparam int MAX_FR     = 6;
    localparam int WD_LIMIT   = 180000;

    typedef struct packed {
        logic [7:0] div;
        logic       lsb;
        logic       ral;
        logic       lri;
        logic       bci;
        logic       alt;
        logic [1:0] prec;
    } bcfg_t;

    logic             clk;
    logic             rst_n;
    logic [DIV_W-1:0] cfg_div;
    logic             cfg_lsb_first, cfg_right_align, cfg_lr_invert;
    logic             cfg_bclk_invert, cfg_alt_frame;
    logic [1:0]       cfg_prec;
    logic [23:0]      left_in, right_in;
    logic             in_valid, in_ready, bclk, lrck, sdata;

    int checks, fails, cyc;
    logic wd_hit;

    logic cap_on, cap_inv, prev_ro, ro;
    logic cap_sd [MAX_CAP];
    logic cap_lr [MAX_CAP];
    int   cap_t  [MAX_CAP];
    int   cap_n;
    logic ready_prev;
    int   ready_dbl;

    bcfg_t       fc [MAX_FR];
    logic [23:0] fl [MAX_FR];
    logic [23:0] fr [MAX_FR];
    logic        fv [MAX_FR];
    int          nfr;

    pcm_serial_tx #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .cfg_lsb_first(cfg_lsb_first), .cfg_right_align(cfg_right_align),
        .cfg_lr_invert(cfg_lr_invert), .cfg_bclk_invert(cfg_bclk_invert),
        .cfg_alt_frame(cfg_alt_frame), .cfg_prec(cfg_prec),
        .left_in(left_in), .right_in(right_in), .in_valid(in_valid),
        .in_ready(in_ready), .bclk(bclk), .lrck(lrck), .sdata(sdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_LIMIT) wd_hit = 1'b1;
    end

    // Capture data and word clock at each edge where data must be stable.
    always @(negedge clk) begin
        if (!cap_on) begin
            cap_n   = 0;
            prev_ro = 1'b1;
        end else begin
            ro = bclk ^ cap_inv;
            if (ro && !prev_ro && cap_n < MAX_CAP) begin
                cap_sd[cap_n] = sdata;
                cap_lr[cap_n] = lrck;
                cap_t[cap_n]  = cyc;
                cap_n = cap_n + 1;
            end
            prev_ro = ro;
        end
    end

    // Ready must never be seen high on two consecutive cycles (R9).
    always @(negedge clk) begin
        if (rst_n && in_ready && ready_prev) ready_dbl = ready_dbl + 1;
        ready_prev = in_ready;
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic bcfg_t mk(input int d, input logic lsb, input logic ral,
                                 input logic lri, input logic bci, input logic alt,
                                 input int prec);
        bcfg_t c;
        c.div = 8'(d); c.lsb = lsb; c.ral = ral; c.lri = lri;
        c.bci = bci; c.alt = alt; c.prec = 2'(prec);
        return c;
    endfunction

    function automatic int slot_w(input bcfg_t c);
        return (c.prec == 2'd0) ? 16 : 32;
    endfunction

    function automatic int sample_n(input bcfg_t c);
        case (c.prec)
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    // Expected data bit at frame position p (R3, R4, R5).
    function automatic logic exp_sd(input bcfg_t c, input int p,
                                    input logic [23:0] l, input logic [23:0] r);
        int w, n, s;
        logic [31:0] m, word, smp;
        w   = slot_w(c);
        n   = sample_n(c);
        s   = p % w;
        smp = {8'd0, (p >= w) ? r : l};
        if (c.prec == 2'd0) begin
            if (c.lsb) return smp[s];
            return smp[15 - s];
        end
        m = (32'd1 << n) - 32'd1;
        smp = smp & m;
        if (c.ral) word = smp;
        else       word = smp << (32 - n);
        return word[31 - s];
    endfunction

    // Expected word-clock level at frame position p (R6, R7).
    function automatic logic exp_lr(input bcfg_t c, input int p);
        int w, q;
        w = slot_w(c);
        q = c.alt ? p : ((p + 1) % (2 * w));
        return logic'(q >= w) ^ c.lri;
    endfunction

    task automatic drive_frame(input int f);
        cfg_div         = fc[f].div;
        cfg_lsb_first   = fc[f].lsb;
        cfg_right_align = fc[f].ral;
        cfg_lr_invert   = fc[f].lri;
        cfg_bclk_invert = fc[f].bci;
        cfg_alt_frame   = fc[f].alt;
        cfg_prec        = fc[f].prec;
        in_valid        = fv[f];
        left_in         = fl[f];
        right_in        = fr[f];
    endtask

    task automatic set_frame(input int f, input bcfg_t c, input logic v);
        fc[f] = c;
        fv[f] = v;
        fl[f] = 24'($urandom);
        fr[f] = 24'($urandom);
    endtask

    task automatic run_scn(input string tag);
        int k;
        drive_frame(0);
        cap_on  = 1'b0;
        cap_inv = fc[0].bci;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        chk(bclk == 1'b1,     {"R1 bclk in reset ", tag}, int'(bclk), 1);
        chk(lrck == 1'b0,     {"R1 lrck in reset ", tag}, int'(lrck), 0);
        chk(sdata == 1'b0,    {"R1 sdata in reset ", tag}, int'(sdata), 0);
        chk(in_ready == 1'b0, {"R1 ready in reset ", tag}, int'(in_ready), 0);
        rst_n  = 1'b1;
        cap_on = 1'b1;
        for (int f = 0; f < nfr; f++) begin
            if (f > 0) drive_frame(f);
            do @(negedge clk); while (!in_ready && !wd_hit);
            @(negedge clk);
        end
        in_valid = 1'b0;
        do @(negedge clk); while (!in_ready && !wd_hit);
        repeat (2) @(negedge clk);
        k = 0;
        for (int f = 0; f < nfr; f++) begin
            int w2, bad, pbad, a_v, e_v, dbad, per;
            w2 = 2 * slot_w(fc[f]);
            per = 2 * (int'(fc[f].div) + 1);
            bad = 0; pbad = 0; a_v = 0; e_v = 0; dbad = 0;
            if (k + w2 > cap_n) begin
                chk(1'b0, $sformatf("R2 R9 frame %0d bits missing %s", f, tag), cap_n, k + w2);
            end else begin
                for (int p = 0; p < w2; p++) begin
                    logic es, el;
                    es = exp_sd(fc[f], p, fv[f] ? fl[f] : 24'd0, fv[f] ? fr[f] : 24'd0);
                    el = exp_lr(fc[f], p);
                    if (cap_sd[k+p] !== es || cap_lr[k+p] !== el) begin
                        if (bad == 0) begin
                            a_v = p * 4 + int'({cap_lr[k+p], cap_sd[k+p]});
                            e_v = p * 4 + int'({el, es});
                        end
                        bad++;
                    end
                    if (p > 0 && (cap_t[k+p] - cap_t[k+p-1]) != per) begin
                        if (pbad == 0) dbad = cap_t[k+p] - cap_t[k+p-1];
                        pbad++;
                    end
                end
                chk(bad == 0, $sformatf("R3 R4 R5 R6 R7 R8 R11%s frame %0d bits(pos*4+lr*2+sd) %s",
                                        fv[f] ? "" : " R10", f, tag), a_v, e_v);
                chk(pbad == 0, $sformatf("R2 bit period frame %0d %s", f, tag), dbad, per);
            end
            k += w2;
        end
        cap_on = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        bcfg_t c;
        checks = 0; fails = 0; cyc = 0; wd_hit = 1'b0;
        ready_dbl = 0; ready_prev = 1'b0;
        cap_on = 1'b0; cap_inv = 1'b0; prev_ro = 1'b1; ro = 1'b0; cap_n = 0;
        rst_n = 1'b0; in_valid = 1'b0; left_in = '0; right_in = '0;
        cfg_div = '0; cfg_lsb_first = 0; cfg_right_align = 0; cfg_lr_invert = 0;
        cfg_bclk_invert = 0; cfg_alt_frame = 0; cfg_prec = '0;
        void'($urandom(32'd71523));

        // Directed: 16-bit, MSB first, I2S, plain polarities.
        nfr = 4;
        for (int f = 0; f < 4; f++) set_frame(f, mk(1, 0, 0, 0, 0, 0, 0), 1'b1);
        run_scn("d16_msb_i2s");
        // Directed: 16-bit LSB first, padding bit set (ignored), alt framing, inverted word clock.
        for (int f = 0; f < 4; f++) set_frame(f, mk(0, 1, 1, 1, 0, 1, 0), 1'b1);
        run_scn("d16_lsb_alt_R5");
        // Directed: 24-bit right-padded, order bit set (ignored), bit clock inverted.
        nfr = 3;
        for (int f = 0; f < 3; f++) set_frame(f, mk(2, 1, 0, 0, 1, 0, 3), 1'b1);
        run_scn("d24_left_R4_R8");
        // Directed: 18-bit right-aligned, alt framing.
        for (int f = 0; f < 3; f++) set_frame(f, mk(3, 1, 1, 0, 0, 1, 1), 1'b1);
        run_scn("d18_right");
        // Directed: 20-bit with withheld samples (silent frames).
        nfr = 4;
        for (int f = 0; f < 4; f++) set_frame(f, mk(5, 0, 0, 1, 1, 0, 2), logic'(f % 2 == 0));
        run_scn("d20_gaps_R10");
        // Directed: configuration changed in the middle of frames.
        set_frame(0, mk(1, 0, 0, 0, 0, 0, 0), 1'b1);
        set_frame(1, mk(1, 0, 0, 0, 0, 0, 0), 1'b1);
        set_frame(2, mk(2, 0, 1, 1, 0, 1, 3), 1'b1);
        set_frame(3, mk(0, 1, 0, 0, 0, 0, 0), 1'b1);
        run_scn("dcfg_change_R11");

        // Random: per-frame formats, bit-clock polarity fixed per run.
        for (int s = 0; s < 6; s++) begin
            logic bci;
            bci = logic'($urandom_range(0, 1));
            nfr = 3 + int'($urandom_range(0, 2));
            for (int f = 0; f < nfr; f++) begin
                c = mk(int'($urandom_range(0, 6)), logic'($urandom_range(0, 1)),
                       logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)), bci,
                       logic'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
                set_frame(f, c, logic'($urandom_range(0, 3) != 0));
            end
            run_scn($sformatf("rand%0d", s));
        end

        chk(ready_dbl == 0, "R9 ready held longer than one cycle", ready_dbl, 0);
        if (wd_hit) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule